// File: doc/BRIEF.md
# Polyphase Coefficient Table Packing Writer

This block moves one polyphase filter coefficient table into a register-mapped coefficient memory. The source table holds the unique half of a symmetric filter: phases 0 up to half the phase count, each with seven 12-bit taps. The block reads that table through a combinational read port and issues a stream of 32-bit register writes that fill every memory entry (one per phase) with three packed words.

The upper half of the memory is filled from the stored phases in mirrored order, with the tap order reversed, so the memory ends up with a full set of phases. A five-tap mode packs only the inner taps and leaves the last two fields empty. The base address and tap mode are captured when a run starts. After that, writes go out one per accepted cycle under a valid/ready handshake. A one-cycle done pulse marks the end of the run.

Top module: `coef_pack_writer`

## Requirements
- R1: While reset is held and after it is released, wr_valid, busy and done are low until a start is seen.
- R2: Word 0 of an entry carries field a in bits 27:16, field b in bits 15:4 and bits 11:8 of field c in bits 3:0. Bits 31:28 are zero.
- R3: Word 1 carries bits 7:0 of field c in bits 27:20, field d in bits 19:8 and bits 11:4 of field e in bits 7:0. Bits 31:28 are zero.
- R4: Word 2 carries bits 3:0 of field e in bits 27:24, field f in bits 23:12 and field g in bits 11:0. Bits 31:28 are zero.
- R5: With cfg_five_tap low, fields a..g are taps 0..6. With it high, fields a..e are taps 1..5, and f and g are zero. On tbl_taps, tap k sits in bits [12k+11:12k].
- R6: Entry e with e <= N/2 is built from phase e in the tap order of R5. Entry e > N/2 is built from phase N-e with the tap order reversed (a..g = taps 6..0, or a..e = taps 5..1 in five-tap mode). Here N = NUM_PHASES.
- R7: The address of word w of entry e is base + w*4*N + 4*e. The base is the cfg_base value captured at start, and changes to cfg_base during a run have no effect.
- R8: A write is transferred on each cycle with wr_valid and wr_ready both high. While wr_ready is low, wr_valid stays high and wr_addr and wr_data hold.
- R9: Exactly 3*N writes are issued. In the cycle after the last transfer, done is high for one cycle and busy and wr_valid are low.
- R10: A start pulse during a run is ignored: the run continues unchanged and no second run follows it.
- R11: Writes go entry by entry from entry 0 to entry N-1, and within an entry in the order word 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle) |
| cfg_base | input | ADDR_W | Coefficient memory base address |
| cfg_five_tap | input | 1 | Select five-tap packing |
| tbl_phase | output | PHASE_W | Phase index presented to the table |
| tbl_taps | input | 7*12 | Taps of the addressed phase, tap k at bits 12k+11:12k |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write sink can accept |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with NUM_PHASES=16 and ADDR_W=32. This gives nine stored phases, seven mirrored entries and a word stride of 0x40. Every one of the 48 writes in a run is therefore compared in both data and address against a model that concatenates the seven fields and slices them into three words. Random tables, bases, modes and wr_ready duty cycles exercise back-pressure at any point in a run. An all-ones table puts set bits on every nibble and byte split. Random 32-bit bases reach address wrap-around.

// File: rtl/cpw_pkg.sv
package cpw_pkg;
  localparam int COEF_W   = 12;
  localparam int NUM_TAPS = 7;
  localparam int WORD_W   = 32;
  localparam int WORDS_PER_ENTRY = 3;

  typedef logic [COEF_W-1:0] coef_t;
  typedef coef_t [NUM_TAPS-1:0] tapvec_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/cpw_sequencer.sv
module cpw_sequencer
  import cpw_pkg::*;
#(
  parameter int NUM_PHASES = 16,
  localparam int ENTRY_W = $clog2(NUM_PHASES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               accept,
  output logic               running,
  output logic               launch,
  output logic               finish_pulse,
  output logic [ENTRY_W-1:0] entry_idx,
  output logic [1:0]         word_idx
);
  localparam logic [ENTRY_W-1:0] LAST_ENTRY = ENTRY_W'(NUM_PHASES - 1);
  localparam logic [1:0]         LAST_WORD  = 2'(WORDS_PER_ENTRY - 1);

  run_state_e         state_q, state_d;
  logic [ENTRY_W-1:0] entry_q, entry_d;
  logic [1:0]         word_q, word_d;
  logic               fin_q, fin_d;
  logic               last_write;

  assign last_write = (entry_q == LAST_ENTRY) && (word_q == LAST_WORD);
  assign launch     = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    entry_d = entry_q;
    word_d  = word_q;
    fin_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          entry_d = '0;
          word_d  = '0;
        end
      end
      ST_RUN: begin
        if (accept) begin
          if (word_q == LAST_WORD) begin
            word_d = '0;
            if (last_write) begin
              state_d = ST_IDLE;
              fin_d   = 1'b1;
            end else begin
              entry_d = entry_q + 1'b1;
            end
          end else begin
            word_d = word_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      entry_q <= '0;
      word_q  <= '0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      entry_q <= entry_d;
      word_q  <= word_d;
      fin_q   <= fin_d;
    end
  end

  assign running      = (state_q == ST_RUN);
  assign finish_pulse = fin_q;
  assign entry_idx    = entry_q;
  assign word_idx     = word_q;
endmodule

// File: rtl/cpw_tap_select.sv
module cpw_tap_select
  import cpw_pkg::*;
#(
  parameter int NUM_PHASES = 16,
  localparam int ENTRY_W = $clog2(NUM_PHASES),
  localparam int STORED  = NUM_PHASES / 2 + 1,
  localparam int PHASE_W = $clog2(STORED)
) (
  input  logic [ENTRY_W-1:0]         entry_idx,
  input  logic                       five_tap,
  input  logic [NUM_TAPS*COEF_W-1:0] raw_taps,
  output logic [PHASE_W-1:0]         phase_idx,
  output tapvec_t                    fields
);
  localparam int HALF = NUM_PHASES / 2;

  logic                       mirrored;
  logic [ENTRY_W:0]           entry_ext;
  logic [ENTRY_W:0]           phase_ext;
  tapvec_t                    taps;

  assign entry_ext = {1'b0, entry_idx};
  assign mirrored  = entry_ext > (ENTRY_W+1)'(HALF);
  assign phase_ext = mirrored ? (ENTRY_W+1)'(NUM_PHASES) - entry_ext : entry_ext;
  assign phase_idx = PHASE_W'(phase_ext);

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_unpack
    assign taps[t] = raw_taps[t*COEF_W +: COEF_W];
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_field
    localparam int FWD7 = k;
    localparam int REV7 = NUM_TAPS - 1 - k;
    localparam int FWD5 = (k < NUM_TAPS - 2) ? k + 1 : 0;
    localparam int REV5 = (k < NUM_TAPS - 2) ? NUM_TAPS - 2 - k : 0;
    localparam bit LIVE5 = (k < NUM_TAPS - 2);
    always_comb begin
      if (five_tap) begin
        if (LIVE5) fields[k] = mirrored ? taps[REV5] : taps[FWD5];
        else       fields[k] = '0;
      end else begin
        fields[k] = mirrored ? taps[REV7] : taps[FWD7];
      end
    end
  end
endmodule

// File: rtl/cpw_word_pack.sv
module cpw_word_pack
  import cpw_pkg::*;
(
  input  tapvec_t           fields,
  input  logic [1:0]        word_idx,
  output logic [WORD_W-1:0] word
);
  coef_t fa, fb, fc, fd, fe, ff, fg;
  logic [WORD_W-1:0] w0, w1, w2;

  assign fa = fields[0];
  assign fb = fields[1];
  assign fc = fields[2];
  assign fd = fields[3];
  assign fe = fields[4];
  assign ff = fields[5];
  assign fg = fields[6];

  assign w0 = {4'h0, fa, fb, fc[11:8]};
  assign w1 = {4'h0, fc[7:0], fd, fe[11:4]};
  assign w2 = {4'h0, fe[3:0], ff, fg};

  always_comb begin
    unique case (word_idx)
      2'd0:    word = w0;
      2'd1:    word = w1;
      2'd2:    word = w2;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/coef_pack_writer.sv
module coef_pack_writer
  import cpw_pkg::*;
#(
  parameter int NUM_PHASES = 16,
  parameter int ADDR_W     = 32,
  localparam int ENTRY_W = $clog2(NUM_PHASES),
  localparam int STORED  = NUM_PHASES / 2 + 1,
  localparam int PHASE_W = $clog2(STORED),
  localparam int TAPS_W  = NUM_TAPS * COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_five_tap,
  output logic [PHASE_W-1:0] tbl_phase,
  input  logic [TAPS_W-1:0] tbl_taps,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  localparam int WORD_STRIDE = 4 * NUM_PHASES;

  logic               running, launch, fin;
  logic [ENTRY_W-1:0] entry_idx;
  logic [1:0]         word_idx;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic               five_q, five_d;
  tapvec_t            fields;
  logic [ADDR_W-1:0]  entry_off, word_off;

  cpw_sequencer #(.NUM_PHASES(NUM_PHASES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .accept       (wr_valid & wr_ready),
    .running      (running),
    .launch       (launch),
    .finish_pulse (fin),
    .entry_idx    (entry_idx),
    .word_idx     (word_idx)
  );

  always_comb begin
    base_d = base_q;
    five_d = five_q;
    if (launch) begin
      base_d = cfg_base;
      five_d = cfg_five_tap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      five_q <= 1'b0;
    end else begin
      base_q <= base_d;
      five_q <= five_d;
    end
  end

  cpw_tap_select #(.NUM_PHASES(NUM_PHASES)) u_sel (
    .entry_idx (entry_idx),
    .five_tap  (five_q),
    .raw_taps  (tbl_taps),
    .phase_idx (tbl_phase),
    .fields    (fields)
  );

  cpw_word_pack u_pack (
    .fields   (fields),
    .word_idx (word_idx),
    .word     (wr_data)
  );

  assign entry_off = ADDR_W'(entry_idx) << 2;
  assign word_off  = ADDR_W'(word_idx) * ADDR_W'(WORD_STRIDE);
  assign wr_addr   = base_q + word_off + entry_off;
  assign wr_valid  = running;
  assign busy      = running;
  assign done      = fin;
endmodule

// File: rtl/cpw_checker.sv
module cpw_checker
  import cpw_pkg::*;
#(
  parameter int NUM_PHASES = 16,
  parameter int ADDR_W     = 32,
  parameter int PHASE_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic [PHASE_W-1:0] tbl_phase,
  input logic              busy,
  input logic              done
);
  localparam int TOTAL = WORDS_PER_ENTRY * NUM_PHASES;
  logic [15:0] xfer_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   xfer_cnt <= '0;
    else if (done)                xfer_cnt <= '0;
    else if (wr_valid && wr_ready) xfer_cnt <= xfer_cnt + 1'b1;
  end

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (xfer_cnt == 16'(TOTAL)) && !busy);

  a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (32'(tbl_phase) <= NUM_PHASES / 2));

  a_r2_top_nibble_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[31:28] == 4'h0));
endmodule

bind coef_pack_writer cpw_checker #(
  .NUM_PHASES (NUM_PHASES),
  .ADDR_W     (ADDR_W),
  .PHASE_W    (PHASE_W)
) u_cpw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .tbl_phase (tbl_phase),
  .busy      (busy),
  .done      (done)
);

// File: tb/coef_pack_writer_tb.sv
module coef_pack_writer_tb;
  localparam int N      = 16;
  localparam int STORED = N / 2 + 1;
  localparam int AW     = 32;

  logic        clk, rst_n, start, five, wr_ready;
  logic [AW-1:0] base;
  logic [3:0]  tbl_phase;
  logic [83:0] tbl_taps;
  logic        wr_valid, busy, done;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [83:0] tbl_row [STORED];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  coef_pack_writer #(.NUM_PHASES(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(base),
    .cfg_five_tap(five), .tbl_phase(tbl_phase), .tbl_taps(tbl_taps),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb tbl_taps = (int'(tbl_phase) < STORED) ? tbl_row[tbl_phase] : '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] tap_of(input int p, input int t);
    return tbl_row[p][t*12 +: 12];
  endfunction

  function automatic logic [31:0] exp_word(input int e, input int w, input bit m5);
    int p;
    bit rev;
    logic [83:0] cat;
    logic [11:0] f;
    rev = (e > N / 2);
    p   = rev ? N - e : e;
    cat = '0;
    for (int k = 0; k < 7; k++) begin
      if (m5) f = (k < 5) ? (rev ? tap_of(p, 5 - k) : tap_of(p, k + 1)) : 12'h0;
      else    f = rev ? tap_of(p, 6 - k) : tap_of(p, k);
      cat = {cat[71:0], f};
    end
    case (w)
      0:       return {4'h0, cat[83:56]};
      1:       return {4'h0, cat[55:28]};
      default: return {4'h0, cat[27:0]};
    endcase
  endfunction

  task automatic run(input bit m5, input logic [31:0] b, input int ready_pct,
                     input bit all_ones, input bit poke);
    int k;
    int e, w;
    logic [31:0] ew, ea;
    string tg;
    for (int p = 0; p < STORED; p++)
      for (int t = 0; t < 7; t++)
        tbl_row[p][t*12 +: 12] = all_ones ? 12'hFFF : 12'($urandom);
    five  = m5;
    base  = b;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    base  = ~b;      // R7: changes after start must not matter
    five  = ~m5;
    k = 0;
    while (k < 3 * N) begin
      e = k / 3;
      w = k % 3;
      ew = exp_word(e, w, m5);
      ea = b + 32'(w * 4 * N) + 32'(e * 4);
      tg = (w == 0) ? "R2" : (w == 1) ? "R3" : "R4";
      check(wr_valid === 1'b1 && busy === 1'b1 && done === 1'b0, "R9 busy during run (R8 valid held)",
            {61'h0, wr_valid, busy, done}, 64'h6);
      check(wr_data === ew, $sformatf("%s %s R11 entry %0d word %0d", tg,
            m5 ? "R5" : (e > N / 2 ? "R6" : "R6/R5"), e, w), wr_data, ew);
      check(wr_addr === ea, $sformatf("R7 R8 entry %0d word %0d", e, w), wr_addr, ea);
      wr_ready = (int'($urandom % 100) < ready_pct);
      start = (poke && k == 20) ? 1'b1 : 1'b0;   // R10 stray start
      @(posedge clk);
      if (wr_ready) k++;
      @(negedge clk);
    end
    start = 1'b0;
    wr_ready = 1'b0;
    check(done === 1'b1 && busy === 1'b0 && wr_valid === 1'b0, "R9 done after last write",
          {61'h0, done, busy, wr_valid}, 64'h4);
    @(negedge clk);
    check(done === 1'b0 && wr_valid === 1'b0, "R9 R10 done single and no rerun",
          {62'h0, done, wr_valid}, 64'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; five = 1'b0; wr_ready = 1'b0; base = '0;
    for (int p = 0; p < STORED; p++) tbl_row[p] = '0;
    repeat (3) @(negedge clk);
    check(wr_valid === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 in reset",
          {61'h0, wr_valid, busy, done}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(wr_valid === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 after reset",
          {61'h0, wr_valid, busy, done}, 64'h0);
    run(1'b0, 32'h0000_0000, 100, 1'b1, 1'b0);
    run(1'b1, 32'h0000_1000, 100, 1'b1, 1'b0);
    run(1'b0, 32'hFFFF_FFC0, 40, 1'b0, 1'b1);
    run(1'b1, 32'h0000_0200, 60, 1'b0, 1'b1);
    for (int r = 0; r < 6; r++)
      run(1'($urandom), $urandom, 30 + int'($urandom % 70), 1'b0, 1'($urandom));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule